// File: doc/BRIEF.md
# Vertical-Blank Frame Copy Engine

This block sits inside a video controller and moves a frame's worth of bytes from a staging RAM, which the CPU fills, into the display RAM, which the scan-out logic reads. Software prepares an image in the staging RAM, programs a byte count and raises a request bit. The engine looks at that bit only when the timing generator signals the first pixel clock of vertical blank. If a copy is due, the engine takes ownership of the staging RAM. It streams one byte per pixel clock into the display RAM, starting at address zero in both memories. When it finishes, it returns the RAM, clears the request and flags completion. The screen therefore never shows a half-updated frame.

The copy length is limited by the blanking window, the number of pixel clocks between the last visible line and the next frame. A length above that window is clamped and an error flag records the clamp. An auto mode repeats the copy every frame without a request. A completion interrupt, gated by an enable bit, is cleared by writing one to the done flag.

The sequencer has four states. `ST_IDLE` waits for a launch. `ST_COPY` issues one staging read per cycle. `ST_DRAIN` writes the last byte still in flight. `ST_FINISH` is the single completion cycle. The transitions are as follows. `ST_IDLE` goes to `ST_COPY` on a frame-start pulse when a launch is due and the length is non-zero. `ST_IDLE` goes to `ST_FINISH` on such a pulse when the length is zero. `ST_COPY` goes to `ST_DRAIN` on the cycle that issues the last read. `ST_DRAIN` always goes to `ST_FINISH`. `ST_FINISH` always returns to `ST_IDLE`.

Top module: `vblank_copy_dma`

## Requirements
- R1: After reset the control, length and status registers read zero, `irq` is low and no display write occurs.
- R2: A copy launches only on a cycle where `frame_start` is high while idle and either the request bit or the auto bit is set. Setting the request bit between pulses starts nothing. A pulse arriving while a copy runs is ignored.
- R3: A copy of N bytes writes display address k with the byte at staging address k, for k = 0 to N-1 in ascending order, one byte per cycle with no gaps. The first display write is one cycle after the launch edge, because the staging RAM has one cycle of read latency.
- R4: While busy, a CPU read of the staging RAM returns zero, a CPU write to it is ignored, and the engine drives the staging address. When idle, CPU reads return data one cycle after the request and CPU writes are performed.
- R5: Register address 0 is control, with bit 0 the request, bit 1 auto and bit 2 the interrupt enable. Address 1 is the length. Address 2 is status, with bit 0 busy, bit 1 done and bit 2 length error. Control writes are accepted while a copy runs.
- R6: Writing a length above the parameter `WINDOW` stores `WINDOW` and sets the length error bit. Writing a length within range stores it unchanged and clears the error bit.
- R7: Busy lasts N+2 cycles for a length N > 0. Afterwards done reads 1 and the request bit reads 0.
- R8: `irq` equals done AND interrupt enable. Writing status with bit 1 set clears done and so drops `irq`.
- R9: With auto set and the request clear, every `frame_start` pulse that arrives while idle launches a full copy.
- R10: A launch with a length of zero performs no display write, stays busy for one cycle and sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the first pixel of vertical blank |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| cpu_ram_req | input | 1 | CPU staging RAM access request |
| cpu_ram_we | input | 1 | CPU staging RAM write enable |
| cpu_ram_addr | input | ADDR_W | CPU staging RAM address |
| cpu_ram_wdata | input | DATA_W | CPU staging RAM write data |
| cpu_ram_rdata | output | DATA_W | CPU staging RAM read data, zero while busy |
| stg_en | output | 1 | Staging RAM enable |
| stg_we | output | 1 | Staging RAM write enable |
| stg_addr | output | ADDR_W | Staging RAM address |
| stg_wdata | output | DATA_W | Staging RAM write data |
| stg_rdata | input | DATA_W | Staging RAM read data, one cycle after enable |
| dsp_we | output | 1 | Display RAM write enable |
| dsp_addr | output | ADDR_W | Display RAM write address |
| dsp_wdata | output | DATA_W | Display RAM write data |
| irq | output | 1 | Copy-complete interrupt |

## Verification
The assertions assume that `frame_start` is a pulse from the timing generator. They also assume the staging RAM returns data exactly one cycle after an enabled read, and that the CPU port behaves like a plain synchronous requester with no handshake. The stimulus drives `frame_start` for one cycle at a time, and the bench's RAM model has that fixed latency. All CPU and register traffic is applied between clock edges, including mid-copy pokes and a second pulse during a copy. Random lengths span zero up to beyond the window, so the clamp path and the zero-length path are both reached under the same assumptions.

// File: rtl/vcd_pkg.sv
`timescale 1ns/1ps
package vcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COPY   = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } vcd_state_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_LEN  = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;

    localparam int CB_GO    = 0;
    localparam int CB_AUTO  = 1;
    localparam int CB_IRQEN = 2;

    localparam int SB_BUSY = 0;
    localparam int SB_DONE = 1;
    localparam int SB_ERR  = 2;

endpackage

// File: rtl/vcd_regs.sv
`timescale 1ns/1ps
module vcd_regs
    import vcd_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int WINDOW = 36000,
    parameter int LEN_W  = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             finish,
    output logic             go,
    output logic             auto_mode,
    output logic [LEN_W-1:0] len_q,
    output logic             irq
);

    localparam logic [REG_W-1:0] WIN_R = REG_W'(WINDOW);
    localparam logic [LEN_W-1:0] WIN_L = LEN_W'(WINDOW);

    logic go_q, auto_q, irqen_q, done_q, err_q;
    logic wr_ctrl, wr_len, wr_stat;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
        wr_len  = reg_wr && (reg_addr == RA_LEN);
        wr_stat = reg_wr && (reg_addr == RA_STAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q    <= 1'b0;
            auto_q  <= 1'b0;
            irqen_q <= 1'b0;
        end else if (wr_ctrl) begin
            go_q    <= reg_wdata[CB_GO];
            auto_q  <= reg_wdata[CB_AUTO];
            irqen_q <= reg_wdata[CB_IRQEN];
        end else if (finish) begin
            go_q    <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            err_q <= 1'b0;
        end else if (wr_len) begin
            if (reg_wdata > WIN_R) begin
                len_q <= WIN_L;
                err_q <= 1'b1;
            end else begin
                len_q <= reg_wdata[LEN_W-1:0];
                err_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end else if (wr_stat && reg_wdata[SB_DONE]) begin
            done_q <= 1'b0;
        end
    end

    always_comb begin
        go        = go_q;
        auto_mode = auto_q;
        irq       = done_q & irqen_q;
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_GO]    = go_q;
                reg_rdata[CB_AUTO]  = auto_q;
                reg_rdata[CB_IRQEN] = irqen_q;
            end
            RA_LEN:  reg_rdata = REG_W'(len_q);
            RA_STAT: begin
                reg_rdata[SB_BUSY] = busy;
                reg_rdata[SB_DONE] = done_q;
                reg_rdata[SB_ERR]  = err_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R6: an oversize length is clamped to the window and flagged
    a_r6_len_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_len && reg_wdata > WIN_R) |=> (err_q && len_q == WIN_L));

    // R7: the request bit drops after a completion unless software rewrote it
    a_r7_go_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !wr_ctrl) |=> !go_q);

    // R8: done only rises as the result of a completion cycle
    a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !$past(done_q)) |-> $past(finish));

endmodule

// File: rtl/vcd_seq.sv
`timescale 1ns/1ps
module vcd_seq
    import vcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              go,
    input  logic              auto_mode,
    input  logic [LEN_W-1:0]  len_q,
    input  logic [DATA_W-1:0] stg_rdata,
    output logic              busy,
    output logic              finish,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              dsp_we,
    output logic [ADDR_W-1:0] dsp_addr,
    output logic [DATA_W-1:0] dsp_wdata
);

    vcd_state_e state_q, state_d;
    logic [LEN_W-1:0]  rem_q;
    logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
    logic              wr_pend_q;
    logic              launch;

    assign launch = frame_start && (go || auto_mode);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    state_d = (len_q == '0) ? ST_FINISH : ST_COPY;
                end
            end
            ST_COPY: begin
                if (rem_q == LEN_W'(1)) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counters and write pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            wr_pend_q <= 1'b0;
        end else begin
            wr_pend_q <= (state_q == ST_COPY);
            if (state_q == ST_IDLE && launch) begin
                rem_q     <= len_q;
                rd_addr_q <= '0;
            end else if (state_q == ST_COPY) begin
                rem_q     <= rem_q - LEN_W'(1);
                rd_addr_q <= rd_addr_q + ADDR_W'(1);
                wr_addr_q <= rd_addr_q;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        finish    = (state_q == ST_FINISH);
        rd_en     = (state_q == ST_COPY);
        rd_addr   = rd_addr_q;
        dsp_we    = wr_pend_q;
        dsp_addr  = wr_addr_q;
        dsp_wdata = stg_rdata;
    end

    // R2: leaving idle requires a frame-start pulse on the edge before
    a_r2_launch_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) == ST_IDLE) |-> $past(frame_start));

    // R3: the first display write of a burst lands at address zero
    a_r3_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_we && !$past(dsp_we)) |-> (dsp_addr == '0));

    // R3: consecutive display writes step the address by one
    a_r3_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_we && $past(dsp_we)) |-> (dsp_addr == $past(dsp_addr) + ADDR_W'(1)));

endmodule

// File: rtl/vblank_copy_dma.sv
`timescale 1ns/1ps
module vblank_copy_dma
    import vcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int REG_W  = 16,
    parameter int WINDOW = 36000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              cpu_ram_req,
    input  logic              cpu_ram_we,
    input  logic [ADDR_W-1:0] cpu_ram_addr,
    input  logic [DATA_W-1:0] cpu_ram_wdata,
    output logic [DATA_W-1:0] cpu_ram_rdata,
    output logic              stg_en,
    output logic              stg_we,
    output logic [ADDR_W-1:0] stg_addr,
    output logic [DATA_W-1:0] stg_wdata,
    input  logic [DATA_W-1:0] stg_rdata,
    output logic              dsp_we,
    output logic [ADDR_W-1:0] dsp_addr,
    output logic [DATA_W-1:0] dsp_wdata,
    output logic              irq
);

    localparam int LEN_W = $clog2(WINDOW + 1);

    logic              busy, finish, go, auto_mode;
    logic [LEN_W-1:0]  len_q;
    logic              seq_rd_en;
    logic [ADDR_W-1:0] seq_rd_addr;
    logic              cpu_rd_acc_q;

    vcd_regs #(
        .REG_W  (REG_W),
        .WINDOW (WINDOW),
        .LEN_W  (LEN_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .finish    (finish),
        .go        (go),
        .auto_mode (auto_mode),
        .len_q     (len_q),
        .irq       (irq)
    );

    vcd_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .go          (go),
        .auto_mode   (auto_mode),
        .len_q       (len_q),
        .stg_rdata   (stg_rdata),
        .busy        (busy),
        .finish      (finish),
        .rd_en       (seq_rd_en),
        .rd_addr     (seq_rd_addr),
        .dsp_we      (dsp_we),
        .dsp_addr    (dsp_addr),
        .dsp_wdata   (dsp_wdata)
    );

    // staging RAM ownership: the engine while busy, the CPU otherwise
    always_comb begin
        stg_en    = busy ? seq_rd_en   : cpu_ram_req;
        stg_we    = !busy && cpu_ram_req && cpu_ram_we;
        stg_addr  = busy ? seq_rd_addr : cpu_ram_addr;
        stg_wdata = cpu_ram_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rd_acc_q <= 1'b0;
        end else begin
            cpu_rd_acc_q <= cpu_ram_req && !cpu_ram_we && !busy;
        end
    end

    assign cpu_ram_rdata = cpu_rd_acc_q ? stg_rdata : '0;

    // R4: a CPU read issued during a copy returns zero
    a_r4_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_ram_req) |=> (cpu_ram_rdata == '0));

    // R4: the engine never writes the staging RAM and the CPU cannot while busy
    a_r4_no_stage_write: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !stg_we);

    // R3: display writes only occur in the cycle after an engine read
    a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_we |-> $past(seq_rd_en));

endmodule

// File: tb/sim_vblank_copy_dma.sv
`timescale 1ns/1ps
module sim_vblank_copy_dma;
    import vcd_pkg::*;

    localparam int AW  = 10;
    localparam int DW  = 8;
    localparam int RW  = 16;
    localparam int WIN = 600;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          cpu_ram_req = 1'b0;
    logic          cpu_ram_we = 1'b0;
    logic [AW-1:0] cpu_ram_addr = '0;
    logic [DW-1:0] cpu_ram_wdata = '0;
    logic [DW-1:0] cpu_ram_rdata;
    logic          stg_en, stg_we;
    logic [AW-1:0] stg_addr;
    logic [DW-1:0] stg_wdata;
    logic [DW-1:0] stg_rdata = '0;
    logic          dsp_we;
    logic [AW-1:0] dsp_addr;
    logic [DW-1:0] dsp_wdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    vblank_copy_dma #(.ADDR_W(AW), .DATA_W(DW), .REG_W(RW), .WINDOW(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_ram_req(cpu_ram_req), .cpu_ram_we(cpu_ram_we), .cpu_ram_addr(cpu_ram_addr),
        .cpu_ram_wdata(cpu_ram_wdata), .cpu_ram_rdata(cpu_ram_rdata),
        .stg_en(stg_en), .stg_we(stg_we), .stg_addr(stg_addr), .stg_wdata(stg_wdata),
        .stg_rdata(stg_rdata), .dsp_we(dsp_we), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata),
        .irq(irq)
    );

    // staging RAM model, one cycle read latency
    logic [DW-1:0] mem [1 << AW];
    always @(posedge clk) begin
        if (stg_en) begin
            if (stg_we) mem[stg_addr] <= stg_wdata;
            stg_rdata <= mem[stg_addr];
        end
    end

    // intended staging contents, kept by the bench
    logic [DW-1:0] shadow [1 << AW];

    // display write monitor
    int unsigned   wr_cnt = 0, mism = 0, seq_err = 0;
    logic          last_we = 1'b0;
    logic [AW-1:0] last_addr = '0;
    always @(posedge clk) begin
        last_we <= dsp_we;
        if (dsp_we) begin
            last_addr <= dsp_addr;
            wr_cnt    <= wr_cnt + 1;
            if (dsp_wdata !== shadow[dsp_addr]) mism <= mism + 1;
            if (last_we ? (dsp_addr !== last_addr + 1'b1) : (dsp_addr !== '0))
                seq_err <= seq_err + 1;
        end
    end

    function automatic int exp_len(input int req);
        return (req > WIN) ? WIN : req;
    endfunction

    function automatic int exp_busy(input int n);
        return (n == 0) ? 1 : n + 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = RW'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        reg_wr = 1'b0; reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic cpu_rd(input int a, output int v);
        @(negedge clk);
        cpu_ram_req = 1'b1; cpu_ram_we = 1'b0; cpu_ram_addr = AW'(a);
        @(negedge clk);
        cpu_ram_req = 1'b0;
        #1 v = int'(cpu_ram_rdata);
    endtask

    task automatic fill_stage();
        @(negedge clk);
        for (int i = 0; i < (1 << AW); i++) begin
            logic [DW-1:0] b;
            b = DW'($urandom);
            shadow[i] = b;
            cpu_ram_req = 1'b1; cpu_ram_we = 1'b1;
            cpu_ram_addr = AW'(i); cpu_ram_wdata = b;
            @(negedge clk);
        end
        cpu_ram_req = 1'b0; cpu_ram_we = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1; reg_wr = 1'b0; reg_addr = RA_STAT;
        @(negedge clk);
        frame_start = 1'b0;
        #1;
    endtask

    task automatic run_copy(input int req, input bit poke);
        int n, v, cnt;
        int unsigned c0, m0, s0;
        n = exp_len(req);
        wr_reg(RA_LEN, req);
        rd_reg(RA_LEN, v);
        chk(v == n, "R6 length readback", v, n);
        rd_reg(RA_STAT, v);
        chk(v[SB_ERR] == (req > WIN), "R6 error bit", v[SB_ERR], int'(req > WIN));
        wr_reg(RA_CTRL, poke ? 1 : 5);
        c0 = wr_cnt; m0 = mism; s0 = seq_err;
        pulse_frame();
        cnt = 0;
        while (reg_rdata[SB_BUSY] && cnt < 3000) begin
            cnt++;
            if (poke && cnt == 3) begin
                frame_start = 1'b1;
                cpu_ram_req = 1'b1; cpu_ram_we = 1'b0; cpu_ram_addr = AW'(5);
                reg_wr = 1'b1; reg_addr = RA_CTRL; reg_wdata = RW'(4);
                @(negedge clk);
                cnt++;
                frame_start = 1'b0; reg_wr = 1'b0; reg_addr = RA_STAT;
                #1 chk(cpu_ram_rdata == '0, "R4 read while busy", cpu_ram_rdata, 0);
                cpu_ram_we = 1'b1; cpu_ram_wdata = ~shadow[5];
                @(negedge clk);
                cpu_ram_req = 1'b0; cpu_ram_we = 1'b0;
                #1;
            end else begin
                @(negedge clk);
                #1;
            end
        end
        chk(cnt == exp_busy(n), "R7 busy duration", cnt, exp_busy(n));
        repeat (2) @(negedge clk);
        chk(wr_cnt - c0 == n, "R3 write count", int'(wr_cnt - c0), n);
        chk(mism == m0, "R3 data match", int'(mism - m0), 0);
        chk(seq_err == s0, "R3 address order", int'(seq_err - s0), 0);
        rd_reg(RA_STAT, v);
        chk(v[SB_DONE] == 1'b1 && v[SB_BUSY] == 1'b0, "R7 done set", v, 2);
        rd_reg(RA_CTRL, v);
        chk(v[CB_GO] == 1'b0, "R7 request cleared", v[CB_GO], 0);
        if (poke) chk(v == 4, "R5 control write while busy", v, 4);
        #1 chk(irq == 1'b1, "R8 irq raised", irq, 1);
        wr_reg(RA_STAT, 2);
        rd_reg(RA_STAT, v);
        chk(v[SB_DONE] == 1'b0 && irq == 1'b0, "R8 done cleared", v, 0);
        if (poke) begin
            cpu_rd(5, v);
            chk(v == int'(shadow[5]), "R4 write ignored while busy", v, shadow[5]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v, w;
        int unsigned c0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(RA_CTRL, v); chk(v == 0, "R1 control reset", v, 0);
        rd_reg(RA_LEN, v);  chk(v == 0, "R1 length reset", v, 0);
        rd_reg(RA_STAT, v); chk(v == 0, "R1 status reset", v, 0);
        chk(irq == 1'b0 && wr_cnt == 0, "R1 quiet outputs", int'(wr_cnt), 0);

        // normal CPU access when idle (R4)
        fill_stage();
        for (int k = 0; k < 3; k++) begin
            w = $urandom_range(0, (1 << AW) - 1);
            cpu_rd(w, v);
            chk(v == int'(shadow[w]), "R4 idle read", v, shadow[w]);
        end

        // R2 request set without a frame pulse does nothing
        wr_reg(RA_LEN, 30);
        wr_reg(RA_CTRL, 5);
        c0 = wr_cnt;
        repeat (30) @(negedge clk);
        rd_reg(RA_STAT, v);
        chk(v[SB_BUSY] == 1'b0 && wr_cnt == c0, "R2 no launch between frames", v, 0);

        // mid-copy pokes: CPU access, second pulse, control write (R2, R4, R5)
        run_copy(40, 1'b1);

        // R2 pulse with request clear and auto off launches nothing
        c0 = wr_cnt;
        pulse_frame();
        repeat (10) @(negedge clk);
        rd_reg(RA_STAT, v);
        chk(v[SB_BUSY] == 1'b0 && wr_cnt == c0, "R2 no launch without request", int'(wr_cnt - c0), 0);

        // boundaries (R3, R6, R7, R10)
        run_copy(WIN, 1'b0);
        run_copy(WIN + 7, 1'b0);
        run_copy(1, 1'b0);
        run_copy(0, 1'b0);

        // R9 auto mode, two frames
        wr_reg(RA_LEN, 20);
        wr_reg(RA_CTRL, 6);
        for (int f = 0; f < 2; f++) begin
            c0 = wr_cnt;
            pulse_frame();
            repeat (30) @(negedge clk);
            chk(wr_cnt - c0 == 20, "R9 auto copy per frame", int'(wr_cnt - c0), 20);
            rd_reg(RA_STAT, v);
            chk(v[SB_DONE] == 1'b1, "R9 auto done", v, 2);
            wr_reg(RA_STAT, 2);
        end
        wr_reg(RA_CTRL, 0);

        // random lengths with fresh contents
        for (int r = 0; r < 6; r++) begin
            fill_stage();
            run_copy($urandom_range(0, WIN + 40), 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule